// File: doc/BRIEF.md
# Debug Breakpoint and Step Counter Unit

This unit sits beside a processor core and watches its program counter and its instruction-retire strobe. A single register of `CNT_W` bits serves one of two purposes, chosen by control bits. In counter mode it counts retired instructions downward and may stop the core when it reaches zero. In address-match mode it holds a breakpoint address and stops the core when a retiring instruction's program counter equals it. Stopping the core means raising the debug-mode flag, which stays up until software clears it through the control register.

The unit also holds a device-reset request bit, which clears itself when the reset sequencer reports completion. It provides a read-only status byte with two indications: the core is idle (in debug mode, or it has executed a break instruction since the last control write) and the core is halted. All ports are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Control byte layout: bit 7 is debug mode, bit 6 is address-match mode, bit 5 is break-on-zero, and bit 0 is the reset request. Bits 4 to 1 are reserved. Status byte layout: bit 7 is idle, bit 6 is halted, and bits 5 to 0 are zero.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset, the counter, the control byte, the status byte, `dbg_mode_o` and `rst_req_o` are all zero.
- R2: In counter mode (control bit 6 = 0), with debug mode off, each cycle with `step_i` high lowers the counter by one. At zero it holds and never wraps.
- R3: With break-on-zero (bit 5 = 1) in counter mode, the step that takes the counter from 1 to 0 sets debug mode at the same clock edge. With bit 5 = 0, reaching zero does not set debug mode.
- R4: While debug mode is on, steps change neither the counter nor debug mode.
- R5: In address-match mode (bit 6 = 1), with debug mode off, a cycle with `step_i` high and `pc_i` equal to the counter sets debug mode. A cycle with `step_i` low never matches. In this mode the counter never counts.
- R6: Debug mode, once set, stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 sets it.
- R7: When a control write takes debug mode from 1 to 0, the counter is cleared to 0 if bits 5 and 6 were both 0 before that write. Otherwise it keeps its value.
- R8: A control write with bit 0 = 1 sets `rst_req_o`. The bit stays high until a cycle with `rst_done_i` high clears it. A new request in the same cycle wins.
- R9: Status bit 7 (idle) equals debug mode OR the break-seen flag. Status bit 6 (halted) equals debug mode. Status bits 5 to 0 read 0.
- R10: The break-seen flag is set by `brk_i` and cleared by any control write. When both occur in one cycle, the set wins.
- R11: Reserved control bits 4 to 1 are not stored and always read back as 0.
- R12: A write on the counter port loads `cnt_wdata_i` and takes priority over a decrement or an exit clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | CNT_W | Program counter of the retiring instruction |
| step_i | input | 1 | Instruction retire / single-step strobe |
| brk_i | input | 1 | Break instruction executed strobe |
| ctl_wr_i | input | 1 | Control byte write enable |
| ctl_wdata_i | input | 8 | Control byte write data |
| cnt_wr_i | input | 1 | Counter register write enable |
| cnt_wdata_i | input | CNT_W | Counter register write data |
| rst_done_i | input | 1 | Reset sequence finished |
| dbg_mode_o | output | 1 | Debug mode, halts the core |
| rst_req_o | output | 1 | Device reset request |
| ctl_o | output | 8 | Control byte readback |
| cnt_o | output | CNT_W | Counter / breakpoint register |
| stat_o | output | 8 | Status byte |

## Verification
Counter mode is swept over every start value from 1 to 6 with break-on-zero set, so an off-by-one stop or a stop at the wrong count shows up at each step. A short run past zero with break-on-zero cleared tells saturation apart from wrap and from a spurious break. Address-match mode is swept across program counter values on both sides of the breakpoint address, plus one cycle where the address matches but no step strobe is given, which separates a true match from a premature one, from one that ignores the strobe, and from one that lets the register count. Debug entry and exit are repeated under each mode combination to tell the exit clear apart from the keep cases.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int CTL_W   = 8;
  localparam int CB_DBG  = 7;
  localparam int CB_PCM  = 6;
  localparam int CB_ZBK  = 5;
  localparam int CB_RST  = 0;
  localparam int SB_IDLE = 7;
  localparam int SB_HALT = 6;

  typedef struct packed {
    logic dbg;
    logic pcm;
    logic zbk;
    logic rst;
  } ctl_t;

  function automatic logic [CTL_W-1:0] pack_ctl(input ctl_t c);
    logic [CTL_W-1:0] v;
    v         = '0;
    v[CB_DBG] = c.dbg;
    v[CB_PCM] = c.pcm;
    v[CB_ZBK] = c.zbk;
    v[CB_RST] = c.rst;
    return v;
  endfunction
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             hit_i,
  input  logic             rst_done_i,
  output ctl_t             ctl_o,
  output logic             exit_o
);
  ctl_t ctl_q;

  // leaving debug mode through a software write
  assign exit_o = wr_i && ctl_q.dbg && !wdata_i[CB_DBG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_i) begin
        ctl_q.dbg <= wdata_i[CB_DBG];
        ctl_q.pcm <= wdata_i[CB_PCM];
        ctl_q.zbk <= wdata_i[CB_ZBK];
      end else if (hit_i) begin
        ctl_q.dbg <= 1'b1;
      end
      if (wr_i && wdata_i[CB_RST]) ctl_q.rst <= 1'b1;
      else if (rst_done_i)         ctl_q.rst <= 1'b0;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dbg_brk_cnt.sv
module dbg_brk_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_i,
  input  logic             pcm_i,
  input  logic             zbk_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] pc_i,
  input  logic             exit_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             run, dec, zero_hit, pc_hit, keep_on_exit;

  assign run          = !dbg_i;
  assign dec          = run && !pcm_i && step_i && (cnt_q != ZERO);
  assign zero_hit     = dec && zbk_i && (cnt_q == ONE);
  assign pc_hit       = run && pcm_i && step_i && (pc_i == cnt_q);
  assign keep_on_exit = zbk_i || pcm_i;
  assign hit_o        = zero_hit || pc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= ZERO;
    else if (wr_i)                   cnt_q <= wdata_i;
    else if (exit_i && !keep_on_exit) cnt_q <= ZERO;
    else if (dec)                    cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbg_stat.sv
module dbg_stat
  import dbg_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_i,
  input  logic             ctl_wr_i,
  input  logic             dbg_i,
  output logic [CTL_W-1:0] stat_o
);
  logic brk_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_seen_q <= 1'b0;
    else if (brk_i)    brk_seen_q <= 1'b1;
    else if (ctl_wr_i) brk_seen_q <= 1'b0;
  end

  always_comb begin
    stat_o          = '0;
    stat_o[SB_IDLE] = dbg_i || brk_seen_q;
    stat_o[SB_HALT] = dbg_i;
  end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pc_i,
  input  logic             step_i,
  input  logic             brk_i,
  input  logic             ctl_wr_i,
  input  logic [7:0]       ctl_wdata_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             rst_done_i,
  output logic             dbg_mode_o,
  output logic             rst_req_o,
  output logic [7:0]       ctl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       stat_o
);
  ctl_t ctl;
  logic exit_w, hit_w;

  dbg_ctl_regs u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (ctl_wr_i),
    .wdata_i    (ctl_wdata_i),
    .hit_i      (hit_w),
    .rst_done_i (rst_done_i),
    .ctl_o      (ctl),
    .exit_o     (exit_w)
  );

  dbg_brk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbg_i   (ctl.dbg),
    .pcm_i   (ctl.pcm),
    .zbk_i   (ctl.zbk),
    .step_i  (step_i),
    .pc_i    (pc_i),
    .exit_i  (exit_w),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt_o),
    .hit_o   (hit_w)
  );

  dbg_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_i    (brk_i),
    .ctl_wr_i (ctl_wr_i),
    .dbg_i    (ctl.dbg),
    .stat_o   (stat_o)
  );

  assign dbg_mode_o = ctl.dbg;
  assign rst_req_o  = ctl.rst;
  assign ctl_o      = pack_ctl(ctl);
endmodule

// File: rtl/dbg_brk_chk.sv
module dbg_brk_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic             brk_i,
  input logic             ctl_wr_i,
  input logic [7:0]       ctl_wdata_i,
  input logic             cnt_wr_i,
  input logic             rst_done_i,
  input logic             dbg_mode_o,
  input logic             rst_req_o,
  input logic [7:0]       ctl_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [7:0]       stat_o
);
  // R2: no wrap below zero
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !cnt_wr_i) |=> (cnt_o == '0));

  // R4: debug mode freezes the counter
  a_r4_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && !cnt_wr_i && !ctl_wr_i) |=> $stable(cnt_o));

  // R5: address-match mode never counts
  a_r5_pcm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[6] && !cnt_wr_i && !ctl_wr_i) |=> $stable(cnt_o));

  // R6: debug mode is sticky without a control write
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && !ctl_wr_i) |=> dbg_mode_o);

  // R8: completion clears the request unless a new one arrives
  a_r8_rst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done_i && !(ctl_wr_i && ctl_wdata_i[0])) |=> !rst_req_o);

  // R8: request held while not done
  a_r8_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !rst_done_i) |=> rst_req_o);

  // R10: break strobe makes the core read idle
  a_r10_brk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> stat_o[7]);

  // R9: halt flag follows debug mode, low bits zero
  a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[6] == dbg_mode_o) && (stat_o[5:0] == 6'd0));

  // R11: reserved control bits read zero
  a_r11_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[4:1] == 4'd0);

  // R2: a step alone never raises the counter
  a_r2_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_i && step_i && !ctl_wr_i) |=> (cnt_o <= $past(cnt_o)));
endmodule

bind dbg_brk_unit dbg_brk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .brk_i       (brk_i),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_wdata_i (ctl_wdata_i),
  .cnt_wr_i    (cnt_wr_i),
  .rst_done_i  (rst_done_i),
  .dbg_mode_o  (dbg_mode_o),
  .rst_req_o   (rst_req_o),
  .ctl_o       (ctl_o),
  .cnt_o       (cnt_o),
  .stat_o      (stat_o)
);

// File: tb/tb_dbg_brk_unit.sv
module tb_dbg_brk_unit;
  localparam int CNT_W = 16;
  localparam time TCLK = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] pc_i = '0;
  logic             step_i = 1'b0;
  logic             brk_i = 1'b0;
  logic             ctl_wr_i = 1'b0;
  logic [7:0]       ctl_wdata_i = '0;
  logic             cnt_wr_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic             rst_done_i = 1'b0;
  logic             dbg_mode_o, rst_req_o;
  logic [7:0]       ctl_o, stat_o;
  logic [CNT_W-1:0] cnt_o;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  dbg_brk_unit #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .step_i(step_i), .brk_i(brk_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .rst_done_i(rst_done_i), .dbg_mode_o(dbg_mode_o),
    .rst_req_o(rst_req_o), .ctl_o(ctl_o), .cnt_o(cnt_o), .stat_o(stat_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    ctl_wr_i = 1'b1; ctl_wdata_i = d;
    cyc();
    ctl_wr_i = 1'b0; ctl_wdata_i = '0;
  endtask

  task automatic cnt_load(input logic [CNT_W-1:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    cyc();
    cnt_wr_i = 1'b0;
  endtask

  task automatic step_pc(input logic [CNT_W-1:0] pc);
    step_i = 1'b1; pc_i = pc;
    cyc();
    step_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cnt", 32'(cnt_o), 0);
    chk("R1 ctl", 32'(ctl_o), 0);
    chk("R1 stat", 32'(stat_o), 0);
    chk("R1 dbg", 32'(dbg_mode_o), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 rst_req", 32'(rst_req_o), 0);

    // R2 R3: counter sweep with break-on-zero
    for (int s = 1; s <= 6; s++) begin
      cnt_load(CNT_W'(s));
      ctl_write(8'h20);
      for (int k = 1; k <= s; k++) begin
        step_pc('0);
        chk("R2 count", 32'(cnt_o), 32'(s - k));
        chk("R3 zero break", 32'(dbg_mode_o), 32'(s == k));
      end
      // R4: steps in debug mode are ignored
      step_pc('0);
      chk("R4 hold at zero", 32'(cnt_o), 0);
      chk("R4 dbg stays", 32'(dbg_mode_o), 1);
      ctl_write(8'h20);
      chk("R7 zbk exit", 32'(dbg_mode_o), 0);
    end

    // R2 R3: saturation without break-on-zero
    cnt_load(CNT_W'(2));
    ctl_write(8'h00);
    for (int k = 1; k <= 4; k++) begin
      step_pc('0);
      chk("R2 saturate", 32'(cnt_o), 32'((k >= 2) ? 0 : 2 - k));
      chk("R3 no break", 32'(dbg_mode_o), 0);
    end

    // R12: load beats decrement
    cnt_load(CNT_W'(9));
    cnt_wr_i = 1'b1; cnt_wdata_i = CNT_W'(40); step_i = 1'b1;
    cyc();
    cnt_wr_i = 1'b0; step_i = 1'b0;
    chk("R12 load priority", 32'(cnt_o), 40);

    // R4 R6 R7: exit behaviour under each mode
    for (int m = 0; m < 3; m++) begin
      logic [7:0] mb;
      mb = (m == 0) ? 8'h00 : (m == 1) ? 8'h20 : 8'h40;
      cnt_load(CNT_W'(5));
      ctl_write(mb);
      if (m != 2) begin
        step_pc('0); step_pc('0);
      end
      ctl_write(mb | 8'h80);
      chk("R6 enter by write", 32'(dbg_mode_o), 1);
      step_pc('0); step_pc('0);
      chk("R4 frozen", 32'(cnt_o), (m == 2) ? 5 : 3);
      repeat (3) cyc();
      chk("R6 sticky", 32'(dbg_mode_o), 1);
      ctl_write(mb);
      chk("R6 leave", 32'(dbg_mode_o), 0);
      chk("R7 exit value", 32'(cnt_o), (m == 0) ? 0 : (m == 1) ? 3 : 5);
    end

    // R5: address-match sweep
    cnt_load(CNT_W'(16'h0100));
    ctl_write(8'h40);
    pc_i = CNT_W'(16'h0100);
    cyc();
    chk("R5 no strobe no match", 32'(dbg_mode_o), 0);
    for (int d = -3; d <= 3; d++) begin
      step_pc(CNT_W'(32'h100 + d));
      chk("R5 match", 32'(dbg_mode_o), 32'(d >= 0));
      chk("R5 no count", 32'(cnt_o), 32'h100);
    end
    ctl_write(8'h40);
    chk("R5 exit keeps addr", 32'(cnt_o), 32'h100);

    // R8: reset request
    ctl_write(8'h01);
    chk("R8 set", 32'(rst_req_o), 1);
    repeat (3) cyc();
    chk("R8 hold", 32'(rst_req_o), 1);
    rst_done_i = 1'b1; cyc(); rst_done_i = 1'b0;
    chk("R8 clear", 32'(rst_req_o), 0);
    ctl_write(8'h01);
    rst_done_i = 1'b1; ctl_wr_i = 1'b1; ctl_wdata_i = 8'h01;
    cyc();
    rst_done_i = 1'b0; ctl_wr_i = 1'b0;
    chk("R8 new request wins", 32'(rst_req_o), 1);
    rst_done_i = 1'b1; cyc(); rst_done_i = 1'b0;

    // R11: reserved bits
    ctl_write(8'h1E);
    chk("R11 reserved dropped", 32'(ctl_o), 0);
    ctl_write(8'hE0);
    chk("R11 readback", 32'(ctl_o), 32'hE0);
    ctl_write(8'h00);

    // R9 R10: status
    chk("R9 running", 32'(stat_o), 0);
    brk_i = 1'b1; cyc(); brk_i = 1'b0;
    chk("R10 brk seen idle", 32'(stat_o), 32'h80);
    cyc();
    chk("R10 sticky", 32'(stat_o), 32'h80);
    ctl_write(8'h00);
    chk("R10 cleared by write", 32'(stat_o), 0);
    brk_i = 1'b1; ctl_wr_i = 1'b1; ctl_wdata_i = 8'h00;
    cyc();
    brk_i = 1'b0; ctl_wr_i = 1'b0;
    chk("R10 set wins", 32'(stat_o), 32'h80);
    ctl_write(8'h80);
    chk("R9 halted", 32'(stat_o), 32'hC0);
    ctl_write(8'h00);
    chk("R9 back to run", 32'(stat_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule